// File: doc/BRIEF.md
# Calendar Real-Time Clock Core

This block keeps time of day and a calendar date in a byte-wide register file that a host reads and writes by index. A one-second tick input starts an update window. The update-in-progress flag rises at once, and the time advances by one second a fixed number of clock cycles later. The flag stays high for a fixed number of cycles after the update, so a host that sees the flag clear can read a consistent time for at least the lead interval.

Values are held either in packed BCD or in plain binary, and hours run either 0 to 23 or 1 to 12 with a PM flag. Internally the time is decoded to binary 24-hour form, advanced, and encoded back to the selected format. Three alarm bytes (seconds, minutes, hours) are compared with the freshly updated time. An alarm byte with its two top bits set matches any value. A set-mode bit in the second control register freezes the clock so the host can load a new time without a rollover in between.

Top module: `rtc_core`

## Requirements
- R1: Register index 0 is seconds, 1 seconds alarm, 2 minutes, 3 minutes alarm, 4 hours, 5 hours alarm, 6 day of week, 7 day of month, 8 month and 9 year. Index 10 is control A, 11 control B, 12 control C and 13 control D. Reads of 14 and 15 return 0x00, and every index 0 to 9 reads back what was last written to it while set mode was on.
- R2: A high `sec_tick` sampled while UIP is 0 and set mode is off starts an update window. The time advances by exactly one second at the LEAD_CYC-th rising edge after the edge that sampled the tick, and ticks sampled while a window is open are ignored.
- R3: Control A bit 7 (UIP) reads 1 from the edge that samples a starting tick until HOLD_CYC edges after the update edge, and reads 0 at all other times.
- R4: Seconds and minutes count 0 to 59. Seconds wrap from 59 to 0 and carry into minutes, and minutes wrap from 59 to 0 and carry into hours.
- R5: With control B bit 1 = 1, hours count 0 to 23 and wrap to 0 with a carry into the date. With bit 1 = 0, hours hold 1 to 12 in bits 6:0 with bit 7 = 1 for PM, and step 11 AM to 12 PM, 12 PM to 1 PM, 11 PM to 12 AM and 12 AM to 1 AM.
- R6: On a day carry, day of month wraps to 1 after the month's last day, and day of week steps 7 to 1. February has 29 days when year mod 4 = 0 and 28 otherwise. April, June, September and November have 30 days, and all other months have 31. Month wraps 12 to 1 with a carry into year, and year wraps 99 to 0.
- R7: Control B bit 2 = 0 holds all time, date and alarm values as packed BCD (tens in bits 7:4, units in bits 3:0). Bit 2 = 1 holds them as plain binary.
- R8: While control B bit 7 (set) is 1, the time never advances, ticks are ignored and UIP reads 0. Writes to indices 0, 2, 4, 6, 7, 8 and 9 take effect only while set is 1 and are ignored otherwise.
- R9: Alarm bytes (indices 1, 3, 5) can be written at any time. `alarm_evt` is high for exactly one cycle after an update edge when each alarm byte equals its updated time byte or has bits 7:6 = 11.
- R10: Control A bits 6:0 and all of control B read back as written, and writes to A bit 7 have no effect. Control C reads 0x00 and ignores writes. Control D reads 0x80 and ignores writes.
- R11: After reset, seconds, minutes, hours, year and the alarms are 0x00, day of week, day of month and month are 0x01, control A reads 0x00 and control B reads 0x02.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| sec_tick | input | 1 | One-second tick that opens an update window |
| wr_en | input | 1 | Register write strobe |
| addr | input | 4 | Register index for reads and writes |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Combinational read data for `addr` |
| alarm_evt | output | 1 | One-cycle alarm pulse after a matching update |

## Verification
The properties assume the host loads only in-range values for the selected format and hour mode. They also assume a tick is a level sampled once per edge, with no relation to window timing. The stimulus therefore writes every time field through an encoder that mirrors the chosen format, and loads new times only under set mode. It raises ticks both while idle and inside an open window. Sweeps cover every hour in all four format and hour-mode pairs, every seconds and minutes value, and the last day of every month in leap and common years.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam int unsigned REG_SEC    = 0;
  localparam int unsigned REG_SEC_AL = 1;
  localparam int unsigned REG_MIN    = 2;
  localparam int unsigned REG_MIN_AL = 3;
  localparam int unsigned REG_HR     = 4;
  localparam int unsigned REG_HR_AL  = 5;
  localparam int unsigned REG_DOW    = 6;
  localparam int unsigned REG_DOM    = 7;
  localparam int unsigned REG_MON    = 8;
  localparam int unsigned REG_YR     = 9;
  localparam int unsigned REG_CA     = 10;
  localparam int unsigned REG_CB     = 11;
  localparam int unsigned REG_CC     = 12;
  localparam int unsigned REG_CD     = 13;
  localparam int unsigned NUM_TREG   = 10;

  localparam int unsigned B_HOLD = 7;
  localparam int unsigned B_BIN  = 2;
  localparam int unsigned B_H24  = 1;

  typedef struct packed {
    logic [6:0] sec;
    logic [6:0] min;
    logic [6:0] hr;
    logic [6:0] dow;
    logic [6:0] dom;
    logic [6:0] mon;
    logic [6:0] yr;
  } cal_t;

  function automatic logic [6:0] dec_val(input logic [7:0] raw, input logic bcd);
    logic [6:0] tens;
    logic [6:0] ones;
    tens = {3'b000, raw[7:4]};
    ones = {3'b000, raw[3:0]};
    if (bcd) return 7'(tens * 7'd10) + ones;
    else     return raw[6:0];
  endfunction

  function automatic logic [7:0] enc_val(input logic [6:0] v, input logic bcd);
    logic [6:0] t;
    logic [6:0] o;
    t = v / 7'd10;
    o = v % 7'd10;
    if (bcd) return {t[3:0], o[3:0]};
    else     return {1'b0, v};
  endfunction

  function automatic logic [6:0] month_len(input logic [6:0] mon, input logic [6:0] yr);
    case (mon)
      7'd2:                    return (yr[1:0] == 2'b00) ? 7'd29 : 7'd28;
      7'd4, 7'd6, 7'd9, 7'd11: return 7'd30;
      default:                 return 7'd31;
    endcase
  endfunction

  function automatic logic is_alarm_idx(input logic [3:0] a);
    return (a == 4'(REG_SEC_AL)) || (a == 4'(REG_MIN_AL)) || (a == 4'(REG_HR_AL));
  endfunction
endpackage

// File: rtl/rtc_seq.sv
module rtc_seq #(
  parameter int unsigned LEAD_CYC = 4,
  parameter int unsigned HOLD_CYC = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic inhibit,
  output logic uip,
  output logic do_upd
);
  localparam int unsigned TOTAL = LEAD_CYC + HOLD_CYC;
  localparam int unsigned CNT_W = $clog2(TOTAL + 1);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(TOTAL);
  localparam logic [CNT_W-1:0] CNT_UPD  = CNT_W'(HOLD_CYC + 1);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (inhibit)              cnt_d = '0;
    else if (cnt_q != '0)     cnt_d = cnt_q - CNT_W'(1);
    else if (tick)            cnt_d = CNT_LOAD;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign uip    = (cnt_q != '0);
  assign do_upd = (cnt_q == CNT_UPD) && !inhibit;

  AST_UPD_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    do_upd |=> !do_upd); // R2
  AST_TICK_OPENS: assert property (@(posedge clk) disable iff (!rst_n)
    (!uip && tick && !inhibit) |=> uip); // R3
  AST_HELD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    inhibit |=> !uip); // R8

  if (LEAD_CYC >= 2) begin : g_lead
    AST_LEAD_UIP: assert property (@(posedge clk) disable iff (!rst_n)
      do_upd |-> $past(uip)); // R3
  end
endmodule

// File: rtl/rtc_calc.sv
module rtc_calc
  import rtc_pkg::*;
(
  input  cal_t cur,
  output cal_t nxt
);
  logic       c_min;
  logic       c_hr;
  logic       c_day;
  logic       c_mon;
  logic [6:0] dim;

  always_comb begin
    nxt   = cur;
    dim   = month_len(cur.mon, cur.yr);
    c_min = (cur.sec >= 7'd59);
    c_hr  = c_min && (cur.min >= 7'd59);
    c_day = c_hr && (cur.hr >= 7'd23);
    c_mon = c_day && (cur.dom >= dim);

    nxt.sec = c_min ? 7'd0 : cur.sec + 7'd1;
    if (c_min) nxt.min = (cur.min >= 7'd59) ? 7'd0 : cur.min + 7'd1;
    if (c_hr)  nxt.hr  = (cur.hr  >= 7'd23) ? 7'd0 : cur.hr  + 7'd1;
    if (c_day) begin
      nxt.dom = (cur.dom >= dim)   ? 7'd1 : cur.dom + 7'd1;
      nxt.dow = (cur.dow >= 7'd7)  ? 7'd1 : cur.dow + 7'd1;
    end
    if (c_mon) begin
      nxt.mon = (cur.mon >= 7'd12) ? 7'd1 : cur.mon + 7'd1;
      if (cur.mon >= 7'd12) nxt.yr = (cur.yr >= 7'd99) ? 7'd0 : cur.yr + 7'd1;
    end
  end
endmodule

// File: rtl/rtc_alarm.sv
module rtc_alarm #(
  parameter int unsigned NFIELD = 3
) (
  input  logic [NFIELD*8-1:0] now_v,
  input  logic [NFIELD*8-1:0] alm_v,
  output logic                hit
);
  logic [NFIELD-1:0] fld;

  for (genvar i = 0; i < NFIELD; i++) begin : g_fld
    assign fld[i] = (alm_v[i*8+7 -: 2] == 2'b11) || (alm_v[i*8 +: 8] == now_v[i*8 +: 8]);
  end

  assign hit = &fld;
endmodule

// File: rtl/rtc_core.sv
module rtc_core
  import rtc_pkg::*;
#(
  parameter int unsigned LEAD_CYC = 4,
  parameter int unsigned HOLD_CYC = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sec_tick,
  input  logic       wr_en,
  input  logic [3:0] addr,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  output logic       alarm_evt
);
  localparam int unsigned N_ALM = 3;

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_pipe;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_int_n = rst_pipe[1];

  logic [7:0] tr_q [NUM_TREG];
  logic [7:0] tr_d [NUM_TREG];
  logic [6:0] ctla_q, ctla_d;
  logic [7:0] ctlb_q, ctlb_d;
  logic       alarm_q;

  logic bcd, h24, hold;
  assign bcd  = !ctlb_q[B_BIN];
  assign h24  = ctlb_q[B_H24];
  assign hold = ctlb_q[B_HOLD];

  logic uip, upd;
  rtc_seq #(.LEAD_CYC(LEAD_CYC), .HOLD_CYC(HOLD_CYC)) u_seq (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .tick    (sec_tick),
    .inhibit (hold),
    .uip     (uip),
    .do_upd  (upd)
  );

  // decode stored bytes to binary 24-hour form
  cal_t       cur, nxt;
  logic [6:0] hr_low, hr_base;

  always_comb begin
    hr_low   = dec_val({1'b0, tr_q[REG_HR][6:0]}, bcd);
    hr_base  = (hr_low == 7'd12) ? 7'd0 : hr_low;
    cur.sec  = dec_val(tr_q[REG_SEC], bcd);
    cur.min  = dec_val(tr_q[REG_MIN], bcd);
    cur.hr   = h24 ? dec_val(tr_q[REG_HR], bcd)
                   : (tr_q[REG_HR][7] ? hr_base + 7'd12 : hr_base);
    cur.dow  = dec_val(tr_q[REG_DOW], bcd);
    cur.dom  = dec_val(tr_q[REG_DOM], bcd);
    cur.mon  = dec_val(tr_q[REG_MON], bcd);
    cur.yr   = dec_val(tr_q[REG_YR], bcd);
  end

  rtc_calc u_calc (
    .cur (cur),
    .nxt (nxt)
  );

  // encode the advanced time back into the selected format
  logic       pm;
  logic [6:0] h12;
  logic [7:0] h12_enc;
  logic [7:0] hr_enc;

  always_comb begin
    pm      = (nxt.hr >= 7'd12);
    h12     = pm ? nxt.hr - 7'd12 : nxt.hr;
    if (h12 == 7'd0) h12 = 7'd12;
    h12_enc = enc_val(h12, bcd);
    hr_enc  = h24 ? enc_val(nxt.hr, bcd) : {pm, h12_enc[6:0]};
  end

  logic alm_hit;
  rtc_alarm #(.NFIELD(N_ALM)) u_alarm (
    .now_v ({hr_enc, enc_val(nxt.min, bcd), enc_val(nxt.sec, bcd)}),
    .alm_v ({tr_q[REG_HR_AL], tr_q[REG_MIN_AL], tr_q[REG_SEC_AL]}),
    .hit   (alm_hit)
  );

  // next state of the register file
  always_comb begin
    tr_d   = tr_q;
    ctla_d = ctla_q;
    ctlb_d = ctlb_q;
    if (upd) begin
      tr_d[REG_SEC] = enc_val(nxt.sec, bcd);
      tr_d[REG_MIN] = enc_val(nxt.min, bcd);
      tr_d[REG_HR]  = hr_enc;
      tr_d[REG_DOW] = enc_val(nxt.dow, bcd);
      tr_d[REG_DOM] = enc_val(nxt.dom, bcd);
      tr_d[REG_MON] = enc_val(nxt.mon, bcd);
      tr_d[REG_YR]  = enc_val(nxt.yr, bcd);
    end
    if (wr_en) begin
      if (addr < 4'(NUM_TREG)) begin
        if (is_alarm_idx(addr) || hold) tr_d[addr] = wdata;
      end else if (addr == 4'(REG_CA)) begin
        ctla_d = wdata[6:0];
      end else if (addr == 4'(REG_CB)) begin
        ctlb_d = wdata;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      for (int i = 0; i < NUM_TREG; i++) tr_q[i] <= '0;
      tr_q[REG_DOW] <= 8'h01;
      tr_q[REG_DOM] <= 8'h01;
      tr_q[REG_MON] <= 8'h01;
      ctla_q  <= '0;
      ctlb_q  <= 8'h02;
      alarm_q <= 1'b0;
    end else begin
      tr_q    <= tr_d;
      ctla_q  <= ctla_d;
      ctlb_q  <= ctlb_d;
      alarm_q <= upd && alm_hit;
    end
  end

  // read path
  always_comb begin
    rdata = '0;
    if (addr < 4'(NUM_TREG)) begin
      rdata = tr_q[addr];
    end else begin
      case (addr)
        4'(REG_CA): rdata = {uip, ctla_q};
        4'(REG_CB): rdata = ctlb_q;
        4'(REG_CC): rdata = 8'h00;
        4'(REG_CD): rdata = 8'h80;
        default:    rdata = 8'h00;
      endcase
    end
  end

  assign alarm_evt = alarm_q;

  AST_SET_FREEZE: assert property (@(posedge clk) disable iff (!rst_int_n)
    (hold && !wr_en) |=> $stable(tr_q[REG_SEC])); // R8
  AST_ALARM_AFTER_UPD: assert property (@(posedge clk) disable iff (!rst_int_n)
    alarm_evt |-> $past(upd)); // R9
  AST_ALARM_PULSE: assert property (@(posedge clk) disable iff (!rst_int_n)
    alarm_evt |=> !alarm_evt); // R9
endmodule

// File: tb/rtc_core_tb.sv
module rtc_core_tb;
  localparam int LEAD = 4;
  localparam int HOLD = 3;

  logic       clk;
  logic       rst_n;
  logic       sec_tick;
  logic       wr_en;
  logic [3:0] addr;
  logic [7:0] wdata;
  logic [7:0] rdata;
  logic       alarm_evt;

  int n_chk = 0;
  int n_err = 0;
  int alm_cnt = 0;
  bit done = 0;

  rtc_core #(.LEAD_CYC(LEAD), .HOLD_CYC(HOLD)) u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .sec_tick  (sec_tick),
    .wr_en     (wr_en),
    .addr      (addr),
    .wdata     (wdata),
    .rdata     (rdata),
    .alarm_evt (alarm_evt)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  always @(negedge clk) if (alarm_evt) alm_cnt++;

  task automatic chk(input string req, input int got, input int exp);
    n_chk++;
    if (got !== exp) begin
      n_err++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk);
    wr_en = 1'b1; addr = 4'(a); wdata = 8'(d);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic peek(input int a, output int d);
    addr = 4'(a);
    #1;
    d = int'(rdata);
  endtask

  task automatic rd(input int a, output int d);
    @(negedge clk);
    peek(a, d);
  endtask

  function automatic int enc(input int v, input bit bin);
    return bin ? v : ((v / 10) * 16 + (v % 10));
  endfunction

  function automatic int enc_hr(input int h, input bit bin, input bit h24);
    int h12;
    if (h24) return enc(h, bin);
    h12 = (h % 12 == 0) ? 12 : h % 12;
    return ((h >= 12) ? 128 : 0) + enc(h12, bin);
  endfunction

  function automatic int dim(input int mo, input int y);
    if (mo == 2) return (y % 4 == 0) ? 29 : 28;
    if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
    return 31;
  endfunction

  task automatic load(input bit bin, input bit h24, input int s, input int m, input int h,
                      input int dw, input int dm, input int mo, input int y);
    int fmt;
    fmt = (bin ? 4 : 0) + (h24 ? 2 : 0);
    wr(11, 8'h80 + fmt);
    wr(0, enc(s, bin));
    wr(2, enc(m, bin));
    wr(4, enc_hr(h, bin, h24));
    wr(6, enc(dw, bin));
    wr(7, enc(dm, bin));
    wr(8, enc(mo, bin));
    wr(9, enc(y, bin));
    wr(11, fmt);
  endtask

  task automatic tick_full();
    @(negedge clk); sec_tick = 1'b1;
    @(negedge clk); sec_tick = 1'b0;
    repeat (LEAD + HOLD) @(negedge clk);
  endtask

  task automatic finish_up();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: got 0x0 expected 0x1");
      finish_up();
    end
  end

  initial begin
    int v, a0;
    rst_n = 1'b0; sec_tick = 1'b0; wr_en = 1'b0; addr = '0; wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R11 reset state
    rd(0, v);  chk("R11 sec", v, 8'h00);
    rd(4, v);  chk("R11 hr", v, 8'h00);
    rd(6, v);  chk("R11 dow", v, 8'h01);
    rd(7, v);  chk("R11 dom", v, 8'h01);
    rd(8, v);  chk("R11 mon", v, 8'h01);
    rd(10, v); chk("R11 ctla", v, 8'h00);
    rd(11, v); chk("R11 ctlb", v, 8'h02);

    // R1 index map readback
    wr(11, 8'h82);
    for (int i = 0; i < 10; i++) wr(i, 8'h11 + i);
    for (int i = 0; i < 10; i++) begin rd(i, v); chk("R1 readback", v, 8'h11 + i); end
    rd(14, v); chk("R1 idx14", v, 0);
    rd(15, v); chk("R1 idx15", v, 0);

    // R10 control registers
    wr(10, 8'hFF); rd(10, v); chk("R10 ctla ro bit", v, 8'h7F);
    wr(10, 8'h00);
    wr(12, 8'h55); rd(12, v); chk("R10 ctlc", v, 8'h00);
    wr(13, 8'h00); rd(13, v); chk("R10 ctld", v, 8'h80);
    wr(11, 8'h86); rd(11, v); chk("R10 ctlb rw", v, 8'h86);

    // R2 R3 update window timing (BCD, 24h)
    load(0, 1, 10, 20, 5, 1, 1, 1, 0);
    @(negedge clk); sec_tick = 1'b1;
    @(negedge clk); sec_tick = 1'b0;
    peek(10, v); chk("R3 uip rises", v >> 7, 1);
    peek(0, v);  chk("R2 no early update", v, 8'h10);
    repeat (LEAD - 1) @(negedge clk);
    peek(0, v);  chk("R2 before update edge", v, 8'h10);
    peek(10, v); chk("R3 uip in lead", v >> 7, 1);
    @(negedge clk);
    peek(0, v);  chk("R2 update edge", v, 8'h11);
    repeat (HOLD - 1) @(negedge clk);
    peek(10, v); chk("R3 uip in hold", v >> 7, 1);
    @(negedge clk);
    peek(10, v); chk("R3 uip falls", v >> 7, 0);

    // R2 ticks inside window ignored
    @(negedge clk); sec_tick = 1'b1;
    repeat (4) @(negedge clk);
    sec_tick = 1'b0;
    repeat (LEAD + HOLD) @(negedge clk);
    rd(0, v); chk("R2 one step per window", v, 8'h12);

    // R4 seconds sweep, BCD
    for (int s = 0; s < 60; s++) begin
      load(0, 1, s, 7, 3, 2, 15, 6, 30);
      tick_full();
      rd(0, v); chk("R4 sec", v, enc((s + 1) % 60, 0));
      rd(2, v); chk("R4 min carry", v, enc((s == 59) ? 8 : 7, 0));
    end

    // R4 R7 minutes sweep, binary
    for (int m = 0; m < 60; m++) begin
      load(1, 1, 59, m, 3, 2, 15, 6, 30);
      tick_full();
      rd(2, v); chk("R4 R7 min bin", v, (m + 1) % 60);
      rd(4, v); chk("R4 hr carry", v, (m == 59) ? 4 : 3);
    end

    // R5 R7 hours sweep in every format and hour mode
    for (int b = 0; b < 2; b++) begin
      for (int m24 = 0; m24 < 2; m24++) begin
        for (int h = 0; h < 24; h++) begin
          load(b[0], m24[0], 59, 59, h, 3, 10, 5, 21);
          tick_full();
          rd(4, v); chk("R5 R7 hour step", v, enc_hr((h + 1) % 24, b[0], m24[0]));
          rd(7, v); chk("R5 day carry", v, enc((h == 23) ? 11 : 10, b[0]));
        end
      end
    end

    // R6 month ends, leap and common years
    for (int b = 0; b < 2; b++) begin
      for (int y = 20; y < 22; y++) begin
        for (int mo = 1; mo <= 12; mo++) begin
          load(b[0], 1, 59, 59, 23, 7, dim(mo, y), mo, y);
          tick_full();
          rd(7, v); chk("R6 dom wrap", v, enc(1, b[0]));
          rd(8, v); chk("R6 month", v, enc((mo == 12) ? 1 : mo + 1, b[0]));
          rd(9, v); chk("R6 year", v, enc((mo == 12) ? y + 1 : y, b[0]));
          rd(6, v); chk("R6 dow wrap", v, enc(1, b[0]));
        end
      end
    end
    load(0, 1, 59, 59, 23, 2, 28, 2, 20);
    tick_full();
    rd(7, v); chk("R6 leap feb 29", v, 8'h29);
    rd(6, v); chk("R6 dow step", v, 8'h03);
    load(0, 1, 59, 59, 23, 4, 31, 12, 99);
    tick_full();
    rd(9, v); chk("R6 year wrap", v, 8'h00);

    // R8 set mode freezes and ignores ticks
    load(0, 1, 30, 0, 1, 1, 1, 1, 0);
    wr(11, 8'h82);
    @(negedge clk); sec_tick = 1'b1;
    @(negedge clk); sec_tick = 1'b0;
    peek(10, v); chk("R8 uip low in set", v >> 7, 0);
    repeat (LEAD + HOLD) @(negedge clk);
    rd(0, v); chk("R8 frozen", v, 8'h30);
    wr(11, 8'h02);
    wr(0, 8'h45);
    rd(0, v); chk("R8 time write ignored", v, 8'h30);
    wr(1, 8'h33);
    rd(1, v); chk("R9 alarm write any time", v, 8'h33);

    // R9 alarm matching
    load(0, 1, 58, 0, 0, 1, 1, 1, 0);
    wr(1, 8'h59); wr(3, 8'h00); wr(5, 8'h00);
    a0 = alm_cnt; tick_full();
    chk("R9 exact match", alm_cnt - a0, 1);
    a0 = alm_cnt; tick_full();
    chk("R9 mismatch", alm_cnt - a0, 0);
    wr(1, 8'hC0); wr(3, 8'hC0); wr(5, 8'hFF);
    a0 = alm_cnt; tick_full(); tick_full();
    chk("R9 dont care", alm_cnt - a0, 2);
    wr(5, 8'h05);
    a0 = alm_cnt; tick_full();
    chk("R9 hour mismatch", alm_cnt - a0, 0);

    done = 1;
    finish_up();
  end
endmodule